// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block applies a per-component gamma curve to a stream of 24-bit RGB pixels on behalf of several display channels that share one table memory. Every channel owns three 256-entry tables (red, green, blue) holding 8-bit output codes. Software fills the tables through a two-register port. It first loads an address register, optionally with an auto-advance flag. It then streams values into a data register, and each write lands at the current address.

On the pixel side, one pixel per cycle enters together with a valid bit and a channel number. Each channel has an enable input. When the bit is set, the three components are replaced by the entries of that channel's tables. When it is clear, or when the channel number is out of range, the pixel leaves untouched. Both paths take the same two-cycle latency, so output timing does not depend on the enable.

Top module: `gamma_lut`

## Requirements
- R1: After reset, `pix_valid_o` is 0 and `cfg_rdata` reads 0 (address 0, auto-advance flag clear).
- R2: A write with `cfg_sel`=0 loads the address from `cfg_wdata[11:0]` and the auto-advance flag from `cfg_wdata[31]`. `cfg_rdata` then reads {flag, 19 zero bits, address}, and the new value is visible in the cycle after the write.
- R3: A write with `cfg_sel`=1 stores `cfg_wdata[7:0]` at the current address. If the flag is set, the address then rises by one.
- R4: An auto-advancing data write at the last address (2303) moves the address to 0.
- R5: A data write with the flag clear still stores the value, but the address does not change.
- R6: Table address = channel*768 + component*256 + input code. The component numbers are red 0, green 1 and blue 2. In a pixel, red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R7: With `gamma_en_i[ch]` set, each output component equals the entry at the R6 address for that channel, component and input code.
- R8: With `gamma_en_i[ch]` clear, the output pixel equals the input pixel.
- R9: `pix_valid_o` equals `pix_valid_i` from two cycles earlier, and the output pixel belongs to that earlier input. This holds on both the lookup path and the bypass path.
- R10: A pixel whose channel number is 3 or above passes through unchanged, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 selects the data register |
| cfg_wdata | input | 32 | Register write value |
| cfg_rdata | output | 32 | Address register readback |
| gamma_en_i | input | 3 | Per-channel table enable |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_chan_i | input | 2 | Channel of the input pixel |
| pix_i | input | 24 | Input pixel, red in the top byte |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Corrected or bypassed pixel |

## Verification
A register write is sampled on one edge, and its effect on `cfg_rdata` is read half a cycle after that edge. A pixel sampled on edge N appears on the outputs after edge N+1. The bench drives and samples on falling edges. In the pixel streams it compares each output against the pixel it sent two falling edges earlier. The streams run back to back and include gaps in valid, so an off-by-one latency shows up as a mismatch in valid or data. The bench keeps its own copy of the table. That copy is built from the R6 address rule and follows every write it issues, including the writes that do not advance the address.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
   localparam int COMP_N = 3;

   typedef enum logic {
      SEL_ADDR = 1'b0,
      SEL_DATA = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/gamma_bank.sv
module gamma_bank #(
   parameter int DEPTH = 768,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      rdata <= mem[raddr];
   end

   // R6: decoded write index stays inside this colour bank
   a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/gamma_regport.sv
module gamma_regport
   import gamma_lut_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int ENTRIES = 256,
   parameter int DW      = 8,
   parameter int CFG_W   = 32,
   localparam int TOTAL  = NUM_CH * COMP_N * ENTRIES,
   localparam int AW     = $clog2(TOTAL),
   localparam int BAW    = $clog2(NUM_CH * ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic [COMP_N-1:0] wr_en,
   output logic [BAW-1:0]    wr_idx,
   output logic [DW-1:0]     wr_data
);
   localparam int CH_SPAN = COMP_N * ENTRIES;
   localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

   logic [AW-1:0] addr_q;
   logic          inc_q;
   logic          addr_wr, data_wr;
   logic [AW-1:0] ch_w, rem_w, comp_w, idx_w, bix_w;

   assign addr_wr = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_ADDR);
   assign data_wr = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_DATA);

   always_comb begin
      ch_w   = addr_q / AW'(CH_SPAN);
      rem_w  = addr_q % AW'(CH_SPAN);
      comp_w = rem_w / AW'(ENTRIES);
      idx_w  = rem_w % AW'(ENTRIES);
      bix_w  = ch_w * AW'(ENTRIES) + idx_w;
   end

   assign wr_idx  = bix_w[BAW-1:0];
   assign wr_data = cfg_wdata[DW-1:0];

   for (genvar c = 0; c < COMP_N; c++) begin : g_wen
      assign wr_en[c] = data_wr && (comp_w == AW'(c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         inc_q  <= 1'b0;
      end else if (addr_wr) begin
         addr_q <= (cfg_wdata[AW-1:0] <= LAST) ? cfg_wdata[AW-1:0] : '0;
         inc_q  <= cfg_wdata[CFG_W-1];
      end else if (data_wr && inc_q) begin
         addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
      end
   end

   assign cfg_rdata = {inc_q, {(CFG_W-1-AW){1'b0}}, addr_q};

   a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_wr && cfg_wdata[AW-1:0] <= LAST) |=>
         (addr_q == $past(cfg_wdata[AW-1:0]) && inc_q == $past(cfg_wdata[CFG_W-1])));
   a_r3_autoinc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && inc_q && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1));
   a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && inc_q && addr_q == LAST) |=> (addr_q == '0));
   a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !inc_q) |=> $stable(addr_q));
   a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
   import gamma_lut_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int DW      = 8,
   parameter int ENTRIES = 256,
   parameter int CFG_W   = 32,
   localparam int CHW    = $clog2(NUM_CH),
   localparam int PW     = COMP_N * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic [NUM_CH-1:0] gamma_en_i,
   input  logic              pix_valid_i,
   input  logic [CHW-1:0]    pix_chan_i,
   input  logic [PW-1:0]     pix_i,
   output logic              pix_valid_o,
   output logic [PW-1:0]     pix_o
);
   localparam int BDEPTH = NUM_CH * ENTRIES;
   localparam int BAW    = $clog2(BDEPTH);
   localparam int ENPAD  = 2 ** CHW;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("gamma_lut: NUM_CH must be at least 2");
   end
   if (ENTRIES != 2 ** DW) begin : g_bad_depth
      $error("gamma_lut: ENTRIES must cover every input code");
   end
   if ($clog2(NUM_CH * COMP_N * ENTRIES) > CFG_W - 1) begin : g_bad_cfg
      $error("gamma_lut: address does not fit the register width");
   end

   logic [COMP_N-1:0] wr_en;
   logic [BAW-1:0]    wr_idx;
   logic [DW-1:0]     wr_data;

   gamma_regport #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .DW(DW), .CFG_W(CFG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

   logic [ENPAD-1:0] en_pad;
   logic             en_sel;
   logic [CHW-1:0]   ch_safe;
   assign en_pad  = ENPAD'(gamma_en_i);
   assign en_sel  = en_pad[pix_chan_i];
   assign ch_safe = (int'(pix_chan_i) < NUM_CH) ? pix_chan_i : '0;

   logic          s1_valid, s1_en, s2_valid, s2_en;
   logic [PW-1:0] s1_pix, s2_pix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_en    <= 1'b0;
         s2_valid <= 1'b0;
         s2_en    <= 1'b0;
      end else begin
         s1_valid <= pix_valid_i;
         s1_en    <= en_sel;
         s2_valid <= s1_valid;
         s2_en    <= s1_en;
      end
   end

   always_ff @(posedge clk) begin
      s1_pix <= pix_i;
      s2_pix <= s1_pix;
   end

   for (genvar c = 0; c < COMP_N; c++) begin : g_comp
      localparam int HI = (COMP_N - c) * DW - 1;
      logic [BAW-1:0] s1_raddr;
      logic [DW-1:0]  rd;

      always_ff @(posedge clk) begin
         s1_raddr <= BAW'(ch_safe) * BAW'(ENTRIES) + BAW'(pix_i[HI -: DW]);
      end

      gamma_bank #(.DEPTH(BDEPTH), .DW(DW)) u_bank (
         .clk(clk), .rst_n(rst_n), .we(wr_en[c]), .waddr(wr_idx),
         .wdata(wr_data), .raddr(s1_raddr), .rdata(rd));

      assign pix_o[HI -: DW] = s2_en ? rd : s2_pix[HI -: DW];
   end

   assign pix_valid_o = s2_valid;

   logic [1:0] live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          live <= '0;
      else if (live != 2'd2) live <= live + 1'b1;
   end

   a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2)));
   a_r8_bypass_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd2 && $past(pix_valid_i, 2) && !$past(en_sel, 2))
         |-> (pix_o == $past(pix_i, 2)));
   a_r10_bad_chan_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_i && int'(pix_chan_i) >= NUM_CH) |-> !en_sel);
endmodule

// File: tb/gamma_lut_test.sv
module gamma_lut_test;
   localparam int TOTAL = 2304;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [2:0]  gamma_en_i = '0;
   logic        pix_valid_i = 1'b0;
   logic [1:0]  pix_chan_i = '0;
   logic [23:0] pix_i = '0;
   logic        pix_valid_o;
   logic [23:0] pix_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] tbl [TOTAL];

   always #2.5 clk = ~clk;

   gamma_lut uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gamma_en_i(gamma_en_i),
      .pix_valid_i(pix_valid_i), .pix_chan_i(pix_chan_i), .pix_i(pix_i),
      .pix_valid_o(pix_valid_o), .pix_o(pix_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + (a / 256) * 53 + 3)) ^ 8'hA5;
   endfunction

   function automatic logic [23:0] expect_pix(input int ch, input logic [2:0] en, input logic [23:0] p);
      logic [23:0] r;
      if (ch >= 3 || !en[ch]) return p;
      r[23:16] = tbl[ch*768 + 0*256 + int'(p[23:16])];
      r[15:8]  = tbl[ch*768 + 1*256 + int'(p[15:8])];
      r[7:0]   = tbl[ch*768 + 2*256 + int'(p[7:0])];
      return r;
   endfunction

   task automatic reg_wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 valid after reset", 32'(pix_valid_o), 32'd0);
      check("R1 readback after reset", cfg_rdata, 32'd0);
   endtask

   task automatic t_addr_reg();
      reg_wr(1'b0, 32'h8000_0123);
      check("R2 readback flag+addr", cfg_rdata, 32'h8000_0123);
      reg_wr(1'b0, 32'h0000_02FF);
      check("R2 readback addr no flag", cfg_rdata, 32'h0000_02FF);
   endtask

   task automatic t_load();
      reg_wr(1'b0, 32'h8000_0000);
      for (int a = 0; a < TOTAL; a++) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = {24'h0, pat(a)};
         tbl[a] = pat(a);
         if (a == 10) check("R3 address advanced by ten", cfg_rdata, 32'h8000_000A);
      end
      @(negedge clk);
      cfg_we = 1'b0;
      check("R4 full load wraps address", cfg_rdata, 32'h8000_0000);
   endtask

   task automatic t_wrap();
      reg_wr(1'b0, 32'h8000_08FF);
      check("R2 load last address", cfg_rdata, 32'h8000_08FF);
      reg_wr(1'b1, {24'h0, pat(TOTAL-1)});
      check("R4 last address wraps", cfg_rdata, 32'h8000_0000);
   endtask

   task automatic t_hold();
      reg_wr(1'b0, 32'h0000_0005);
      reg_wr(1'b1, 32'h0000_0011);
      reg_wr(1'b1, 32'h0000_003C);
      tbl[5] = 8'h3C;
      check("R5 address held", cfg_rdata, 32'h0000_0005);
   endtask

   task automatic t_stream(input string req, input int mode, input int n);
      logic [23:0] eq [64];
      logic        vq [64];
      for (int i = 0; i < n + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            check({req, " valid latency (R9)"}, 32'(pix_valid_o), 32'(vq[i-2]));
            if (vq[i-2]) check(req, 32'(pix_o), 32'(eq[i-2]));
         end else begin
            check({req, " idle before stream (R9)"}, 32'(pix_valid_o), 32'd0);
         end
         if (i < n) begin
            logic [23:0] p;
            int ch;
            logic [2:0] en;
            p = {8'(i*37 + mode), 8'(i*91 + 5), 8'(i*13 + 200)};
            if (mode == 0 && i == 0) p[23:16] = 8'd5;
            ch = (mode == 2) ? 3 : i % 3;
            en = (mode == 0) ? 3'b111 : (mode == 1) ? 3'b000 : (mode == 2) ? 3'b111 : 3'b101;
            pix_valid_i = (mode == 3) ? (i % 3 != 1) : 1'b1;
            pix_chan_i = 2'(ch);
            pix_i = p;
            gamma_en_i = en;
            vq[i] = pix_valid_i;
            eq[i] = expect_pix(ch, en, p);
         end else begin
            pix_valid_i = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_reg();
      t_load();
      t_wrap();
      t_hold();
      t_stream("R7 R6 lookup all channels", 0, 24);
      t_stream("R8 bypass when disabled", 1, 12);
      t_stream("R10 channel 3 passes", 2, 8);
      t_stream("R7 R8 mixed enables with gaps", 3, 30);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule